// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Arbiter

This block sits between a set of interrupt request lines and a processor core. Each request line has a fixed priority equal to its index. Each line also has its own acknowledge line. A per-line mask register that the processor writes gates every request before any arbitration. A line is a candidate only if its request is held, its mask bit is set, and its index is strictly greater than the processor's current priority. The core supplies that priority from its status word.

While any candidate exists, the arbiter raises a pending indication and presents the highest candidate's level. The core writes that level into its status word when it takes the interrupt. When the core grants, the arbiter sends a one-cycle acknowledge to the winning line and registers the level it served. The core then raises its own priority to that level. Lines at that level or below are held off, and lines above it can still interrupt the service routine, so requests nest.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, every acknowledge output is 0, the pending output is 0, the served-level output is 0 and every mask bit is clear, so no request is pending until the mask is written.
- R2: Line i takes part in arbitration only while mask bit i is 1. A masked request raises no pending indication and receives no acknowledge.
- R3: A mask write (bit i of the write data sets the mask for line i) takes effect from the clock edge that samples the write strobe. The pending and level outputs follow the new mask in the cycle right after that edge. Before that edge, they follow the old mask.
- R4: Line i is a candidate only when i is strictly greater than the current-priority input. Line 0 is never a candidate, and a current priority of 0 admits lines 1 to 7.
- R5: The pending output is 1 exactly when at least one candidate exists. The new-priority output then equals the index of the highest candidate, and it is 0 when no candidate exists. Both outputs are combinational in the current inputs and the stored mask.
- R6: A grant sampled at a clock edge while the pending output is 1 produces, in the following cycle, an acknowledge vector with only the bit of the winning line set. The served-level output loads the winning index at that same edge.
- R7: A grant sampled while nothing is pending produces no acknowledge and leaves the served-level output unchanged.
- R8: The acknowledge vector is nonzero only in the cycle right after a clock edge that sampled a grant with a pending request. It returns to zero as soon as the grant is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_LEVELS | Request lines; bit i has priority i |
| ack_o | output | NUM_LEVELS | Acknowledge lines, one-cycle pulse to the served line |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NUM_LEVELS | New mask; bit i = 1 enables line i |
| cur_prio_i | input | clog2(NUM_LEVELS) | Current processor priority from the status word |
| grant_i | input | 1 | Processor accepts the pending interrupt |
| irq_o | output | 1 | A candidate request is pending |
| new_prio_o | output | clog2(NUM_LEVELS) | Level to load into the status word on acceptance |
| sel_level_o | output | clog2(NUM_LEVELS) | Level served at the most recent accepted grant |

## Verification
The hardest situation to reach is one where the mask, the threshold and the priority order all matter at once. An example is a high line that is requested but masked, a middle line that sits just at the current priority, and a lower line that must still lose. The bench sweeps every request pattern against every current-priority value with all lines enabled, granting on each combination. It then sweeps every mask value with all lines requesting. For each mask value it checks the cycle in which the write is still pending as well as the cycle after the write has landed.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned IRQ_LEVELS_DEFAULT = 8;

    function automatic int unsigned lvl_bits(input int unsigned levels);
        return (levels > 1) ? $clog2(levels) : 1;
    endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int unsigned NUM_LEVELS = irq_arb_pkg::IRQ_LEVELS_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [NUM_LEVELS-1:0] wdata_i,
    input  logic [NUM_LEVELS-1:0] req_i,
    output logic [NUM_LEVELS-1:0] masked_o
);

    logic [NUM_LEVELS-1:0] mask_d;
    logic [NUM_LEVELS-1:0] mask_q;

    always_comb begin
        mask_d = mask_q;
        if (we_i) begin
            mask_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign masked_o = req_i & mask_q;

endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
    parameter int unsigned NUM_LEVELS = irq_arb_pkg::IRQ_LEVELS_DEFAULT,
    localparam int unsigned LW = irq_arb_pkg::lvl_bits(NUM_LEVELS)
) (
    input  logic [NUM_LEVELS-1:0] masked_i,
    input  logic [LW-1:0]         cur_prio_i,
    output logic [NUM_LEVELS-1:0] eligible_o
);

    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_line
        if (i == 0) begin : g_floor
            // level 0 can never exceed any processor priority
            assign eligible_o[i] = 1'b0;
        end else begin : g_cmp
            assign eligible_o[i] = masked_i[i] && (LW'(i) > cur_prio_i);
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NUM_LEVELS = irq_arb_pkg::IRQ_LEVELS_DEFAULT,
    localparam int unsigned LW = irq_arb_pkg::lvl_bits(NUM_LEVELS)
) (
    input  logic [NUM_LEVELS-1:0] eligible_i,
    output logic                  any_o,
    output logic [LW-1:0]         level_o
);

    always_comb begin
        any_o   = 1'b0;
        level_o = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (eligible_i[i]) begin
                any_o   = 1'b1;
                level_o = LW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
    parameter int unsigned NUM_LEVELS = irq_arb_pkg::IRQ_LEVELS_DEFAULT,
    localparam int unsigned LW = irq_arb_pkg::lvl_bits(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] req_i,
    output logic [NUM_LEVELS-1:0] ack_o,
    input  logic                  mask_we_i,
    input  logic [NUM_LEVELS-1:0] mask_wdata_i,
    input  logic [LW-1:0]         cur_prio_i,
    input  logic                  grant_i,
    output logic                  irq_o,
    output logic [LW-1:0]         new_prio_o,
    output logic [LW-1:0]         sel_level_o
);

    typedef struct packed {
        logic [NUM_LEVELS-1:0] ack;
        logic [LW-1:0]         sel;
    } arb_state_t;

    logic [NUM_LEVELS-1:0] masked;
    logic [NUM_LEVELS-1:0] eligible;
    logic                  any_cand;
    logic [LW-1:0]         win_level;
    arb_state_t            st_d;
    arb_state_t            st_q;

    irq_mask_bank #(.NUM_LEVELS(NUM_LEVELS)) mask_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (mask_we_i),
        .wdata_i  (mask_wdata_i),
        .req_i    (req_i),
        .masked_o (masked)
    );

    irq_level_gate #(.NUM_LEVELS(NUM_LEVELS)) gate_i (
        .masked_i   (masked),
        .cur_prio_i (cur_prio_i),
        .eligible_o (eligible)
    );

    irq_prio_pick #(.NUM_LEVELS(NUM_LEVELS)) pick_i (
        .eligible_i (eligible),
        .any_o      (any_cand),
        .level_o    (win_level)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = '0;
        if (grant_i && any_cand) begin
            st_d.ack            = '0;
            st_d.ack[win_level] = 1'b1;
            st_d.sel            = win_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o       = st_q.ack;
    assign sel_level_o = st_q.sel;
    assign irq_o       = any_cand;
    assign new_prio_o  = win_level;

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
    parameter int unsigned NUM_LEVELS = irq_arb_pkg::IRQ_LEVELS_DEFAULT,
    localparam int unsigned LW = irq_arb_pkg::lvl_bits(NUM_LEVELS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_LEVELS-1:0] req_i,
    input logic [NUM_LEVELS-1:0] ack_o,
    input logic                  grant_i,
    input logic [LW-1:0]         cur_prio_i,
    input logic                  irq_o,
    input logic [LW-1:0]         new_prio_o,
    input logic [LW-1:0]         sel_level_o
);

    // R6
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    // R6
    ack_matches_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0) |-> ack_o[sel_level_o]);

    // R4
    ack_above_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0) |-> (sel_level_o > $past(cur_prio_i)));

    // R2
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0) |-> ((ack_o & ~$past(req_i)) == '0));

    // R8
    ack_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0) |-> $past(grant_i && irq_o));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o == '0) |-> $stable(sel_level_o));

    // R5
    pend_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (new_prio_o > cur_prio_i));

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (new_prio_o == '0));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.NUM_LEVELS(NUM_LEVELS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ack_o       (ack_o),
    .grant_i     (grant_i),
    .cur_prio_i  (cur_prio_i),
    .irq_o       (irq_o),
    .new_prio_o  (new_prio_o),
    .sel_level_o (sel_level_o)
);

// File: tb/irq_prio_arbiter_tb_top.sv
module irq_prio_arbiter_tb_top;

    localparam int N  = 8;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic [N-1:0]  ack_o;
    logic          mask_we_i = 1'b0;
    logic [N-1:0]  mask_wdata_i = '0;
    logic [LW-1:0] cur_prio_i = '0;
    logic          grant_i = 1'b0;
    logic          irq_o;
    logic [LW-1:0] new_prio_o;
    logic [LW-1:0] sel_level_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_arbiter #(.NUM_LEVELS(N)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .ack_o        (ack_o),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .cur_prio_i   (cur_prio_i),
        .grant_i      (grant_i),
        .irq_o        (irq_o),
        .new_prio_o   (new_prio_o),
        .sel_level_o  (sel_level_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // highest index i with bit set and i > prio; -1 when none
    function automatic int top_cand(input logic [N-1:0] v, input int prio);
        int r = -1;
        for (int i = 1; i < N; i++) begin
            if (v[i] && i > prio) r = i;
        end
        return r;
    endfunction

    task automatic write_mask(input logic [N-1:0] m);
        @(negedge clk);
        mask_we_i    = 1'b1;
        mask_wdata_i = m;
        @(negedge clk);
        mask_we_i    = 1'b0;
    endtask

    initial begin
        int exp_sel;
        int hi;
        logic [N-1:0] old_mask;

        repeat (3) @(negedge clk);
        req_i = '1;
        #1;
        // R1: reset state, mask cleared
        chk("R1 ack", int'(ack_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 sel", int'(sel_level_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after release, mask clear", int'(irq_o), 0);
        chk("R1 ack after release", int'(ack_o), 0);

        // R7: grant with nothing pending
        grant_i = 1'b1;
        @(negedge clk);
        chk("R7 no ack", int'(ack_o), 0);
        chk("R7 sel held", int'(sel_level_o), 0);
        grant_i = 1'b0;

        // sweep: all lines enabled, every request pattern x every priority
        write_mask('1);
        exp_sel = 0;
        for (int p = 0; p < N; p++) begin
            for (int r = 0; r < (1 << N); r++) begin
                req_i      = N'(r);
                cur_prio_i = LW'(p);
                grant_i    = 1'b1;
                #1;
                hi = top_cand(N'(r), p);
                // R4 / R5
                chk("R5 irq", int'(irq_o), (hi >= 0) ? 1 : 0);
                chk("R4 new_prio", int'(new_prio_o), (hi >= 0) ? hi : 0);
                @(negedge clk);
                // R6 / R7
                if (hi >= 0) exp_sel = hi;
                chk("R6 ack", int'(ack_o), (hi >= 0) ? (1 << hi) : 0);
                chk("R6 sel", int'(sel_level_o), exp_sel);
                grant_i = 1'b0;
                @(negedge clk);
                // R8
                chk("R8 ack cleared", int'(ack_o), 0);
            end
        end

        // sweep: every mask value, all lines requesting, priority 0
        req_i      = '1;
        cur_prio_i = '0;
        old_mask   = '1;
        for (int m = 0; m < (1 << N); m++) begin
            @(negedge clk);
            mask_we_i    = 1'b1;
            mask_wdata_i = N'(m);
            #1;
            hi = top_cand(old_mask, 0);
            // R3: old mask until the write edge
            chk("R3 before edge", int'(new_prio_o), (hi >= 0) ? hi : 0);
            @(negedge clk);
            mask_we_i = 1'b0;
            hi = top_cand(N'(m), 0);
            // R2 / R3
            chk("R2 irq masked", int'(irq_o), (hi >= 0) ? 1 : 0);
            chk("R3 new_prio", int'(new_prio_o), (hi >= 0) ? hi : 0);
            old_mask = N'(m);
        end

        // R2: masked high line loses to enabled lower line under grant
        write_mask(8'b0010_0100);
        req_i      = 8'b1010_0100;
        cur_prio_i = 3'd1;
        grant_i    = 1'b1;
        @(negedge clk);
        chk("R2 masked line skipped", int'(ack_o), 8'b0010_0000);
        chk("R2 sel", int'(sel_level_o), 5);
        // nesting: priority raised to 5, level 7 unmasked arrives
        cur_prio_i = 3'd5;
        grant_i    = 1'b0;
        write_mask('1);
        #1;
        chk("R4 nested level", int'(new_prio_o), 7);
        grant_i = 1'b1;
        @(negedge clk);
        chk("R6 nested ack", int'(ack_o), 8'b1000_0000);
        grant_i = 1'b0;
        @(negedge clk);
        chk("R8 nested ack cleared", int'(ack_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule